// File: doc/BRIEF.md
# Parallel Bus Request/Acknowledge Output Engine

This block sends data words to an initiator over a parallel bus with a fully interlocked request/acknowledge handshake, acting as the target side of the exchange. Both strobes are active low. For every transfer cycle the engine places a word on the data lines, pulls the request strobe low, and waits for the initiator to pull acknowledge low. At that point it releases the request strobe and, in the same clock, pulls the next word from its source into a staging register. It waits for acknowledge to return high before it opens the next cycle. A new cycle opens only when the next word is already staged, so a release of acknowledge can never get ahead of the fetch.

A transfer starts with a cycle count, and more cycles can be added while it runs. When the count reaches zero and acknowledge has been released, the engine returns to idle. It then releases the bus and gives a one-cycle completion pulse. If cycles are added after the count has reached zero but before the engine has stopped, the engine fetches the first new word, presents it and carries on. An abort input ends the transfer at once. The acknowledge input is asynchronous and passes through a synchroniser before any edge is detected.

Top module: `hs_out_engine`

## Requirements
- R1: After reset, req_n is 1, data_oe is 0, data_out is 0, busy is 0, done is 0 and src_pop is 0.
- R2: A start pulse with a nonzero start_count enters the busy state. The first word is fetched and appears on data_out, with data_oe at 1, at least one clock before req_n first goes low. A start pulse with start_count of 0 is ignored.
- R3: ack_n is synchronised through two flops. When ack_n falls between clock edges while req_n is low, req_n is still 0 after the second rising edge and is 1 after the third.
- R4: On the edge where req_n rises after an ack_n fall, the remaining count drops by one. If further cycles remain and src_valid is 1, the next word is loaded onto data_out in that same edge.
- R5: data_out does not change while req_n is held low.
- R6: req_n goes low only when the synchronised acknowledge is high and a new word is staged. While src_valid is 0 and no word is staged, req_n stays 1.
- R7: Exactly as many words are taken from the source (src_pop pulses) as there are transfer cycles. They reach data_out in the order taken.
- R8: A topup_valid pulse while busy adds topup_count to the remaining cycles. A pulse while idle has no effect on the next transfer.
- R9: A top-up that arrives after the count has reached zero, while acknowledge is still low, makes the engine fetch the first new word and present it on data_out before the next request. The transfer then continues.
- R10: When the count is zero and acknowledge has been released, the engine goes idle. req_n is then 1, data_oe 0 and data_out 0, and done is 1 for exactly one clock.
- R11: A stop pulse while busy makes the engine idle at the next edge, with req_n 1, data_oe 0 and a one-clock done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| start_count | input | CNT_W | Number of cycles for the new transfer |
| stop | input | 1 | Abort the running transfer |
| topup_valid | input | 1 | Add cycles to the running transfer |
| topup_count | input | CNT_W | Number of cycles to add |
| src_valid | input | 1 | Source has a word ready on src_word |
| src_word | input | DW | Next word from the source |
| src_pop | output | 1 | Source word is taken at this edge |
| ack_n | input | 1 | Asynchronous acknowledge from the initiator, active low |
| req_n | output | 1 | Request strobe, active low |
| data_out | output | DW | Data lines to the bus |
| data_oe | output | 1 | Drive enable for the data lines |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse when the engine returns to idle |

## Verification
The hardest case to reach is a top-up that lands in the short window after the last counted cycle has seen its acknowledge fall but before acknowledge is released. In that window the count is zero and nothing is staged. The bench acting as initiator holds acknowledge low, injects the top-up there and checks that the first new word appears on the data lines before acknowledge is released. A second hard case is a release of acknowledge with no word staged. The bench creates it by dropping src_valid in the cycle acknowledge falls, then confirms that the request stays high until the source recovers.

// File: rtl/hs_out_pkg.sv
// Package: shared types for the request/acknowledge output engine.
// Assumes: nothing; holds the sequencer state encoding only.
package hs_out_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // bus released, waiting for start
        ST_GAP  = 2'd1,   // request high, waiting for word and acknowledge release
        ST_SEND = 2'd2    // request low, waiting for acknowledge
    } eng_state_t;
endpackage

// File: rtl/hs_ack_sync.sv
// Module: brings the asynchronous active-low acknowledge into the clock
// domain and flags its falling edge on the synchronised level.
// Assumes: STAGES >= 2; the released (high) level is the reset value.
module hs_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    output logic ack_high,
    output logic ack_fall
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    // Synchroniser chain, one flop per stage.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= ack_n;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    // Delayed copy of the synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain[STAGES-1];
    end

    assign ack_high = chain[STAGES-1];
    assign ack_fall = prev_q & ~chain[STAGES-1];
endmodule

// File: rtl/hs_cycle_count.sv
// Module: remaining-cycle counter with load, decrement and top-up add.
// Assumes: the caller keeps the total within CNT_W bits; load wins over
// decrement and add in the same cycle.
module hs_cycle_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Next count: load, or subtract the finished cycle and add any top-up.
    always_comb begin
        if (load) count_nxt = load_val;
        else      count_nxt = count - (dec ? ONE : '0) + (add_en ? add_val : '0);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nxt;
    end
endmodule

// File: rtl/hs_word_stage.sv
// Module: staging register for the word on the bus, with a flag that
// marks a freshly fetched word not yet sent by a request.
// Assumes: take and consume are never high together; clear has priority.
module hs_word_stage #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] word_in,
    input  logic          consume,
    input  logic          clear,
    output logic [DW-1:0] word_q,
    output logic          fresh
);
    // Word register and fresh flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word_q <= '0;
            fresh  <= 1'b0;
        end else if (take) begin
            word_q <= word_in;
            fresh  <= 1'b1;
        end else if (consume) begin
            fresh  <= 1'b0;
        end
    end
endmodule

// File: rtl/hs_out_engine.sv
// Module: target-side output engine for an interlocked request/acknowledge
// parallel bus. Sends one staged word per cycle, fetches the next word when
// acknowledge falls, and reopens only with acknowledge high and a word staged.
// Assumes: source words are consumed on src_pop; ack_n is asynchronous.
module hs_out_engine #(
    parameter int DW       = 16,
    parameter int CNT_W    = 12,
    parameter int SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_count,
    input  logic             stop,
    input  logic             topup_valid,
    input  logic [CNT_W-1:0] topup_count,
    input  logic             src_valid,
    input  logic [DW-1:0]    src_word,
    output logic             src_pop,
    input  logic             ack_n,
    output logic             req_n,
    output logic [DW-1:0]    data_out,
    output logic             data_oe,
    output logic             busy,
    output logic             done
);
    import hs_out_pkg::*;

    eng_state_t       state, state_nxt;
    logic             ack_high, ack_fall;
    logic             start_ok, add_en, dec, fetch_win, go_idle, open_cycle;
    logic [CNT_W-1:0] count, count_nxt;
    logic [DW-1:0]    word_q;
    logic             fresh, done_q;

    hs_ack_sync #(.STAGES(SYNC_LEN)) ack_sync_i (
        .clk(clk), .rst_n(rst_n), .ack_n(ack_n),
        .ack_high(ack_high), .ack_fall(ack_fall)
    );

    hs_cycle_count #(.CNT_W(CNT_W)) count_i (
        .clk(clk), .rst_n(rst_n),
        .load(start_ok), .load_val(start_count),
        .dec(dec), .add_en(add_en), .add_val(topup_count),
        .count(count), .count_nxt(count_nxt)
    );

    hs_word_stage #(.DW(DW)) stage_i (
        .clk(clk), .rst_n(rst_n),
        .take(src_pop), .word_in(src_word),
        .consume(open_cycle), .clear(go_idle),
        .word_q(word_q), .fresh(fresh)
    );

    // Handshake events and fetch decision for this cycle.
    always_comb begin
        start_ok   = (state == ST_IDLE) && start && (start_count != '0);
        add_en     = (state != ST_IDLE) && topup_valid;
        dec        = (state == ST_SEND) && ack_fall;
        fetch_win  = ((state == ST_GAP) && !fresh) || dec;
        src_pop    = fetch_win && (count_nxt != '0) && src_valid && !stop;
        open_cycle = (state == ST_GAP) && ack_high && fresh && !stop;
        go_idle    = (state != ST_IDLE) &&
                     (stop || ((state == ST_GAP) && ack_high && !fresh && (count_nxt == '0)));
    end

    // Sequencer next state.
    always_comb begin
        state_nxt = state;
        if (go_idle)                            state_nxt = ST_IDLE;
        else if (start_ok)                      state_nxt = ST_GAP;
        else if (open_cycle)                    state_nxt = ST_SEND;
        else if (dec)                           state_nxt = ST_GAP;
    end

    // Sequencer state and completion pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            state  <= state_nxt;
            done_q <= go_idle;
        end
    end

    assign req_n    = (state != ST_SEND);
    assign data_oe  = (state != ST_IDLE);
    assign busy     = (state != ST_IDLE);
    assign data_out = word_q;
    assign done     = done_q;

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && $past(!req_n)) |-> $stable(data_out)) else $error("data moved under request"); // R5
    AST_REQ_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> ($past(fresh) && $past(ack_high))) else $error("request without staged word"); // R6
    AST_NO_OVERFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> !fresh) else $error("staged word overwritten"); // R7
    AST_REQ_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_n) |-> $past(ack_fall || stop)) else $error("request released without cause"); // R4
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (req_n && !data_oe && (data_out == '0))) else $error("bus held while idle"); // R10
    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one clock"); // R10
endmodule

// File: tb/hs_out_engine_tb_top.sv
// Bench: directed scenarios against the output engine, with the bench acting
// as both data source and initiator.
module hs_out_engine_tb_top;
    localparam int DW    = 16;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] start_count = '0;
    logic             stop = 1'b0;
    logic             topup_valid = 1'b0;
    logic [CNT_W-1:0] topup_count = '0;
    logic             src_valid = 1'b1;
    logic [DW-1:0]    src_word = 16'h1000;
    logic             src_pop;
    logic             ack_n = 1'b1;
    logic             req_n;
    logic [DW-1:0]    data_out;
    logic             data_oe;
    logic             busy;
    logic             done;

    int n_cmp = 0;
    int n_bad = 0;
    int pop_total = 0;
    logic pop_prev = 1'b0;
    logic [DW-1:0] last_data;
    logic          last_oe;

    always #2 clk = ~clk;   // 250 MHz

    hs_out_engine #(.DW(DW), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
        .stop(stop), .topup_valid(topup_valid), .topup_count(topup_count),
        .src_valid(src_valid), .src_word(src_word), .src_pop(src_pop),
        .ack_n(ack_n), .req_n(req_n), .data_out(data_out), .data_oe(data_oe),
        .busy(busy), .done(done)
    );

    // Source model: advance to the next word after each taken word.
    always @(negedge clk) begin
        if (pop_prev) src_word <= src_word + 16'd1;
        pop_prev <= src_pop;
        if (src_pop) pop_total <= pop_total + 1;
    end

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Poll at falling edges until req_n reaches lvl; keeps the prior sample.
    task automatic wait_req(input logic lvl, input string rq);
        int k = 0;
        @(negedge clk);
        while (req_n !== lvl && k < 80) begin
            last_data = data_out;
            last_oe   = data_oe;
            @(negedge clk);
            k++;
        end
        check(rq, "request level reached", {31'd0, req_n}, {31'd0, lvl});
    endtask

    // One full initiator cycle expecting word exp.
    task automatic hs_cycle(input logic [DW-1:0] exp, input string rq);
        wait_req(1'b0, rq);
        check(rq, "word under request", data_out, exp);
        ack_n = 1'b0;
        wait_req(1'b1, rq);
        ack_n = 1'b1;
    endtask

    // Wait for the completion pulse and check the released bus.
    task automatic finish_check(input string rq);
        int k = 0;
        @(negedge clk);
        while (!done && k < 12) begin @(negedge clk); k++; end
        check(rq, "done pulse", {31'd0, done}, 32'd1);
        check(rq, "released bus", {busy, req_n, data_oe, 13'd0, data_out}, {1'b0, 1'b1, 1'b0, 29'd0});
        @(negedge clk);
        check(rq, "done one clock", {31'd0, done}, 32'd0);
    endtask

    task automatic pulse_start(input int n);
        @(negedge clk);
        start = 1'b1; start_count = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", "reset outputs", {req_n, data_oe, busy, done, src_pop, 11'd0, data_out},
              {1'b1, 4'b0, 27'd0});
    endtask

    task automatic t_basic;
        logic [DW-1:0] base = src_word;
        int p0 = pop_total;
        pulse_start(4);
        wait_req(1'b0, "R2");
        check("R2", "word before request", {last_oe, 15'd0, last_data}, {1'b1, 15'd0, base});
        check("R2", "first word", data_out, base);
        ack_n = 1'b0;
        @(negedge clk); check("R3", "req after 1 edge", {31'd0, req_n}, 32'd0);
        @(negedge clk); check("R3", "req after 2 edges", {31'd0, req_n}, 32'd0);
        @(negedge clk); check("R3", "req after 3 edges", {31'd0, req_n}, 32'd1);
        check("R4", "next word same edge", data_out, base + 16'd1);
        ack_n = 1'b1;
        for (int i = 1; i < 4; i++) hs_cycle(base + DW'(i), "R7");
        finish_check("R10");
        check("R7", "words taken", pop_total - p0, 4);
    endtask

    task automatic t_stall;
        logic [DW-1:0] base = src_word;
        int bad = 0;
        src_valid = 1'b0;
        pulse_start(2);
        for (int i = 0; i < 15; i++) begin @(negedge clk); if (!req_n) bad++; end
        check("R6", "no request without word", bad, 0);
        src_valid = 1'b1;
        wait_req(1'b0, "R6");
        check("R6", "first word after stall", data_out, base);
        ack_n = 1'b0; src_valid = 1'b0;
        wait_req(1'b1, "R6");
        ack_n = 1'b1;
        bad = 0;
        for (int i = 0; i < 15; i++) begin @(negedge clk); if (!req_n) bad++; end
        check("R6", "release does not overtake fetch", bad, 0);
        src_valid = 1'b1;
        hs_cycle(base + 16'd1, "R6");
        finish_check("R10");
    endtask

    task automatic t_topup_run;
        logic [DW-1:0] base = src_word;
        int p0 = pop_total;
        pulse_start(2);
        wait_req(1'b0, "R8");
        topup_valid = 1'b1; topup_count = CNT_W'(3);
        @(negedge clk); topup_valid = 1'b0;
        check("R8", "word 0", data_out, base);
        ack_n = 1'b0;
        wait_req(1'b1, "R8");
        ack_n = 1'b1;
        for (int i = 1; i < 5; i++) hs_cycle(base + DW'(i), "R8");
        finish_check("R8");
        check("R8", "words after top-up", pop_total - p0, 5);
    endtask

    task automatic t_topup_zero;
        logic [DW-1:0] base = src_word;
        int p0 = pop_total;
        pulse_start(1);
        wait_req(1'b0, "R9");
        check("R9", "only word", data_out, base);
        ack_n = 1'b0;
        wait_req(1'b1, "R9");
        repeat (4) @(negedge clk);
        check("R9", "still busy at zero", {30'd0, busy, done}, 32'd2);
        topup_valid = 1'b1; topup_count = CNT_W'(2);
        @(negedge clk); topup_valid = 1'b0;
        check("R9", "first new word presented", data_out, base + 16'd1);
        ack_n = 1'b1;
        hs_cycle(base + 16'd1, "R9");
        hs_cycle(base + 16'd2, "R9");
        finish_check("R9");
        check("R9", "words with late top-up", pop_total - p0, 3);
    endtask

    task automatic t_idle_ignore;
        logic [DW-1:0] base;
        int p0 = pop_total;
        @(negedge clk);
        topup_valid = 1'b1; topup_count = CNT_W'(5);
        @(negedge clk); topup_valid = 1'b0;
        pulse_start(0);
        repeat (5) @(negedge clk);
        check("R2", "zero count ignored", {29'd0, busy, req_n, data_oe}, 32'd2);
        check("R2", "no fetch on zero count", pop_total - p0, 0);
        base = src_word;
        pulse_start(2);
        hs_cycle(base, "R8");
        hs_cycle(base + 16'd1, "R8");
        finish_check("R8");
        check("R8", "idle top-up ignored", pop_total - p0, 2);
    endtask

    task automatic t_abort;
        pulse_start(3);
        wait_req(1'b0, "R11");
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        check("R11", "abort state", {busy, req_n, data_oe, done, 12'd0, data_out},
              {1'b0, 1'b1, 1'b0, 1'b1, 28'd0});
        @(negedge clk);
        check("R11", "abort done one clock", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_stall();
        t_topup_run();
        t_topup_zero();
        t_idle_ignore();
        t_abort();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule